// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Command Controller

This block is the device-side logic in a serial flash that moves the part into and out of its lowest-power state. A host selects the device by pulling an active-low select line and clocks in one opcode byte. In single-line mode the byte arrives one bit per serial clock on data line 0. In quad mode it arrives four bits per serial clock. The block knows three opcodes: sleep, wake/signature and software reset. It keeps a four-state power machine (standby, entering, asleep, waking) and runs timed waits in system-clock cycles when it enters or leaves sleep.

While asleep, the block filters the opcode stream so that only wake and reset have any effect. A wake opcode in single-line mode can go on to return an 8-bit signature after three unused address bytes. The signature repeats for as long as the host keeps clocking. Program/erase activity in the rest of the device is seen only through a busy input. All serial inputs are oversampled in the system clock domain through a synchronizer chain.

Top module: `flash_pd_ctrl`

## Requirements
- R1: After hardware reset (power-up), the block is in standby: `pd_active`=0, `transitioning`=0, `so_oe`=0.
- R2: In single-line mode (`qpi_mode`=0) an opcode is the first 8 bits on `sio[0]`, most significant bit first, sampled on serial-clock rising edges. `sio[3:1]` are ignored.
- R3: In quad mode (`qpi_mode`=1) an opcode takes two serial clocks: the high nibble on `sio[3:0]` at the first rising edge, the low nibble at the second.
- R4: Sleep opcode 0xB9 is accepted only if select rises when exactly 8 bits have been clocked. With any other bit count the frame is discarded.
- R5: After an accepted sleep opcode, `transitioning` is high for exactly TDP_CYC system clocks. Then `pd_active` goes high.
- R6: While asleep, a further sleep opcode or any unknown opcode leaves the state unchanged.
- R7: Wake opcode 0xAB, accepted at the 8-bit boundary, leaves sleep through a wait in which `transitioning` is high for exactly TRES_CYC clocks, then returns to standby. From standby it causes no wait.
- R8: In single-line mode, after 0xAB and 24 further bits, the signature SIGNATURE is driven on `so` with `so_oe`=1, MSB first, changing on serial-clock falling edges. It repeats every 8 clocks. Raising select after at least one full signature byte also counts as a wake.
- R9: While `busy` is high, 0xAB neither wakes the block nor drives the signature.
- R10: Software reset opcode 0x99 at the 8-bit boundary returns the block from sleep to standby at once, with no wait.
- R11: A frame whose select falls during a timed wait is ignored entirely, even if it ends after the wait is over.
- R12: `pd_active` and `transitioning` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial interface and run the timers |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Active-low chip select that frames each command |
| sclk | input | 1 | Serial clock from the host |
| sio | input | 4 | Serial data lines; only bit 0 in single-line mode |
| qpi_mode | input | 1 | 1 selects quad (nibble per clock) opcode transfer |
| busy | input | 1 | High while a program/erase/write cycle is running |
| so | output | 1 | Serial signature data out |
| so_oe | output | 1 | Output enable for `so` |
| pd_active | output | 1 | Device is in deep power-down |
| transitioning | output | 1 | An entry or exit wait is in progress |

## Verification
The embedded properties take for granted that each level of `sclk` and `cs_n` lasts for more system clocks than the synchronizer depth. They also assume `sio` is stable while a rising serial edge passes through the chain, and that `qpi_mode` changes only while select is high. The stimulus holds every serial clock phase for four system clocks and drives data only while `sclk` is low. It changes the mode and `busy` only between frames, or with select high, and leaves a gap of several clocks between a select edge and the nearest serial clock edge.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
   typedef enum logic [1:0] {
      PS_STANDBY = 2'd0,
      PS_ENTER   = 2'd1,
      PS_DOWN    = 2'd2,
      PS_WAKE    = 2'd3
   } pstate_e;

   localparam logic [7:0] OPC_SLEEP = 8'hB9;
   localparam logic [7:0] OPC_WAKE  = 8'hAB;
   localparam logic [7:0] OPC_RESET = 8'h99;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
   parameter int           WIDTH   = 1,
   parameter int           STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fpd_frame.sv
module fpd_frame #(
   parameter bit QPI_EN      = 1'b1,
   parameter int DUMMY_BYTES = 3,
   parameter int HIW         = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n_s,
   input  logic           sclk_s,
   input  logic [3:0]     sio_s,
   input  logic           qpi,
   input  logic           lock_req,
   output logic           frame_on,
   output logic           fall_pulse,
   output logic           cs_end,
   output logic           locked,
   output logic [7:0]     opcode,
   output logic [HIW-1:0] byte_cnt,
   output logic [2:0]     bit_lo
);
   localparam int HI_MAX = DUMMY_BYTES + 2;

   logic       cs_q, sclk_q;
   logic       cs_fall, rise_pulse;
   logic [3:0] step;
   logic [7:0] op_nx;
   logic [3:0] lo_sum;

   assign cs_fall    = cs_q & ~cs_n_s;
   assign cs_end     = ~cs_q & cs_n_s & frame_on;
   assign rise_pulse = ~sclk_q & sclk_s & frame_on & ~cs_n_s;
   assign fall_pulse = sclk_q & ~sclk_s & frame_on & ~cs_n_s;

   if (QPI_EN) begin : g_quad
      always_comb begin
         step  = qpi ? 4'd4 : 4'd1;
         op_nx = qpi ? {opcode[3:0], sio_s} : {opcode[6:0], sio_s[0]};
      end
   end else begin : g_single
      always_comb begin
         step  = 4'd1;
         op_nx = {opcode[6:0], sio_s[0]};
      end
   end

   assign lo_sum = {1'b0, bit_lo} + step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         sclk_q   <= 1'b0;
         frame_on <= 1'b0;
         locked   <= 1'b0;
         opcode   <= '0;
         byte_cnt <= '0;
         bit_lo   <= '0;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
         if (cs_fall) begin
            frame_on <= 1'b1;
            locked   <= lock_req;
            opcode   <= '0;
            byte_cnt <= '0;
            bit_lo   <= '0;
         end else if (cs_end) begin
            frame_on <= 1'b0;
         end else if (rise_pulse) begin
            if (byte_cnt == '0) opcode <= op_nx;
            bit_lo <= lo_sum[2:0];
            if (lo_sum[3] && byte_cnt != HIW'(HI_MAX))
               byte_cnt <= byte_cnt + 1'b1;
         end
      end
   end

   // R4
   no_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_on |=> $stable(byte_cnt) || $past(cs_fall));
endmodule

// File: rtl/fpd_power.sv
module fpd_power
   import fpd_pkg::*;
#(
   parameter int TDP_CYC     = 100,
   parameter int TRES_CYC    = 150,
   parameter int DUMMY_BYTES = 3,
   parameter int HIW         = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_end,
   input  logic           locked,
   input  logic [7:0]     opcode,
   input  logic [HIW-1:0] byte_cnt,
   input  logic [2:0]     bit_lo,
   input  logic           qpi,
   input  logic           busy,
   output pstate_e        state,
   output logic           pd_active,
   output logic           transitioning
);
   localparam int TMAX = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
   localparam int TW   = $clog2(TMAX + 1);

   logic    [TW-1:0] tmr;
   logic             cmd_go, exact, sig_done;
   pstate_e          state_nx;
   logic    [TW-1:0] tmr_nx;

   assign cmd_go   = cs_end & ~locked;
   assign exact    = (byte_cnt == HIW'(1)) && (bit_lo == 3'd0);
   assign sig_done = ~qpi && (byte_cnt >= HIW'(DUMMY_BYTES + 2));

   always_comb begin
      state_nx = state;
      tmr_nx   = tmr;
      unique case (state)
         PS_STANDBY: begin
            if (cmd_go && exact && opcode == OPC_SLEEP) begin
               state_nx = PS_ENTER;
               tmr_nx   = TW'(TDP_CYC - 1);
            end
         end
         PS_ENTER: begin
            if (tmr == '0) state_nx = PS_DOWN;
            else           tmr_nx   = tmr - 1'b1;
         end
         PS_DOWN: begin
            if (cmd_go && exact && opcode == OPC_RESET) begin
               state_nx = PS_STANDBY;
            end else if (cmd_go && !busy && opcode == OPC_WAKE &&
                         (exact || sig_done)) begin
               state_nx = PS_WAKE;
               tmr_nx   = TW'(TRES_CYC - 1);
            end
         end
         PS_WAKE: begin
            if (tmr == '0) state_nx = PS_STANDBY;
            else           tmr_nx   = tmr - 1'b1;
         end
         default: state_nx = PS_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_STANDBY;
         tmr   <= '0;
      end else begin
         state <= state_nx;
         tmr   <= tmr_nx;
      end
   end

   assign pd_active     = (state == PS_DOWN);
   assign transitioning = (state == PS_ENTER) || (state == PS_WAKE);

   // R12
   pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_active && transitioning));
   // R5
   enter_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_ENTER && $past(state) != PS_ENTER) |-> tmr == TW'(TDP_CYC - 1));
   // R5
   enter_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == PS_ENTER |=> state == PS_ENTER || state == PS_DOWN);
   // R6
   down_no_reenter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == PS_DOWN |=> state != PS_ENTER);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DOWN && busy) |=> state != PS_WAKE);
   // R11
   lock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> (state == PS_STANDBY || state == PS_DOWN));
endmodule

// File: rtl/fpd_sig.sv
module fpd_sig #(
   parameter logic [7:0] SIGNATURE   = 8'hC5,
   parameter logic [7:0] OPC_WAKE    = 8'hAB,
   parameter int         DUMMY_BYTES = 3,
   parameter int         HIW         = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_on,
   input  logic           locked,
   input  logic           fall_pulse,
   input  logic           cs_end,
   input  logic [7:0]     opcode,
   input  logic [HIW-1:0] byte_cnt,
   input  logic [2:0]     bit_lo,
   input  logic           qpi,
   input  logic           busy,
   output logic           so,
   output logic           so_oe
);
   logic in_window;

   assign in_window = ~locked & ~qpi & (opcode == OPC_WAKE) &
                      (byte_cnt >= HIW'(DUMMY_BYTES + 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so    <= 1'b0;
         so_oe <= 1'b0;
      end else if (cs_end || busy || !frame_on) begin
         so_oe <= 1'b0;
      end else if (fall_pulse && in_window) begin
         so    <= SIGNATURE[~bit_lo];
         so_oe <= 1'b1;
      end
   end

   // R8
   oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> frame_on);
   // R9
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !so_oe);
endmodule

// File: rtl/flash_pd_ctrl.sv
module flash_pd_ctrl
   import fpd_pkg::*;
#(
   parameter int         TDP_CYC     = 100,
   parameter int         TRES_CYC    = 150,
   parameter int         SYNC_STAGES = 2,
   parameter int         DUMMY_BYTES = 3,
   parameter bit         QPI_EN      = 1'b1,
   parameter logic [7:0] SIGNATURE   = 8'hC5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic [3:0] sio,
   input  logic       qpi_mode,
   input  logic       busy,
   output logic       so,
   output logic       so_oe,
   output logic       pd_active,
   output logic       transitioning
);
   localparam int HIW = $clog2(DUMMY_BYTES + 3);

   if (TDP_CYC < 1 || TRES_CYC < 1) begin : g_bad_delay
      $error("delay counts must be at least one cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (DUMMY_BYTES < 0) begin : g_bad_dummy
      $error("dummy byte count must not be negative");
   end

   logic [5:0]     raw_in, syn_in;
   logic           cs_n_s, sclk_s;
   logic [3:0]     sio_s;
   logic           frame_on, fall_pulse, cs_end, locked;
   logic [7:0]     opcode;
   logic [HIW-1:0] byte_cnt;
   logic [2:0]     bit_lo;
   pstate_e        state;
   logic           qpi_eff;

   assign raw_in  = {cs_n, sclk, sio};
   assign qpi_eff = QPI_EN ? qpi_mode : 1'b0;

   fpd_sync #(.WIDTH(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b100000)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   assign cs_n_s = syn_in[5];
   assign sclk_s = syn_in[4];
   assign sio_s  = syn_in[3:0];

   fpd_frame #(.QPI_EN(QPI_EN), .DUMMY_BYTES(DUMMY_BYTES), .HIW(HIW)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sio_s(sio_s),
      .qpi(qpi_eff), .lock_req(transitioning), .frame_on(frame_on),
      .fall_pulse(fall_pulse), .cs_end(cs_end), .locked(locked),
      .opcode(opcode), .byte_cnt(byte_cnt), .bit_lo(bit_lo));

   fpd_power #(.TDP_CYC(TDP_CYC), .TRES_CYC(TRES_CYC),
               .DUMMY_BYTES(DUMMY_BYTES), .HIW(HIW)) u_power (
      .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .locked(locked),
      .opcode(opcode), .byte_cnt(byte_cnt), .bit_lo(bit_lo), .qpi(qpi_eff),
      .busy(busy), .state(state), .pd_active(pd_active),
      .transitioning(transitioning));

   fpd_sig #(.SIGNATURE(SIGNATURE), .OPC_WAKE(OPC_WAKE),
             .DUMMY_BYTES(DUMMY_BYTES), .HIW(HIW)) u_sig (
      .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .locked(locked),
      .fall_pulse(fall_pulse), .cs_end(cs_end), .opcode(opcode),
      .byte_cnt(byte_cnt), .bit_lo(bit_lo), .qpi(qpi_eff), .busy(busy),
      .so(so), .so_oe(so_oe));

   // R1
   standby_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> state == PS_STANDBY && !so_oe);
endmodule

// File: tb/flash_pd_ctrl_bench.sv
module flash_pd_ctrl_bench;
   localparam int         TDP  = 100;
   localparam int         TRES = 150;
   localparam logic [7:0] SIG  = 8'hC5;
   localparam int         H    = 4;
   localparam int         SETTLE = TDP + TRES + 40;
   localparam int         NV   = 11;

   // fields: [39:32] quad, [31:24] bits, [23:16] opcode, [15:8] exp pd, [7:0] wait kind (0 none, 1 entry, 2 exit)
   localparam logic [39:0] VEC [NV] = '{
      {8'd0, 8'd8, 8'hB9, 8'd1, 8'd1},   // R2 R4 R5
      {8'd0, 8'd8, 8'hAB, 8'd0, 8'd2},   // R7
      {8'd0, 8'd7, 8'hB9, 8'd0, 8'd0},   // R4 short
      {8'd0, 8'd9, 8'hB9, 8'd0, 8'd0},   // R4 long
      {8'd1, 8'd8, 8'hB9, 8'd1, 8'd1},   // R3
      {8'd0, 8'd8, 8'hB9, 8'd1, 8'd0},   // R6
      {8'd1, 8'd4, 8'hAB, 8'd1, 8'd0},   // R4 quad half
      {8'd1, 8'd8, 8'hAB, 8'd0, 8'd2},   // R3 R7
      {8'd0, 8'd8, 8'hAB, 8'd0, 8'd0},   // R7 from standby
      {8'd0, 8'd8, 8'hB9, 8'd1, 8'd1},   // R5
      {8'd0, 8'd8, 8'h99, 8'd0, 8'd0}    // R10
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic [3:0] sio = 4'd0;
   logic       qpi_mode = 1'b0;
   logic       busy = 1'b0;
   logic       so, so_oe, pd_active, transitioning;

   int checks = 0;
   int fails  = 0;
   int tcount = 0;
   int both_cnt = 0;
   logic tclr = 1'b0;

   always #10 clk = ~clk;

   flash_pd_ctrl #(.TDP_CYC(TDP), .TRES_CYC(TRES), .SIGNATURE(SIG)) u_flash_pd_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio(sio),
      .qpi_mode(qpi_mode), .busy(busy), .so(so), .so_oe(so_oe),
      .pd_active(pd_active), .transitioning(transitioning));

   always @(posedge clk) begin
      if (tclr) tcount <= 0;
      else if (transitioning) tcount <= tcount + 1;
      if (pd_active && transitioning) both_cnt <= both_cnt + 1;
   end

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr_count();
      tclr = 1'b1; waitc(1); tclr = 1'b0;
   endtask

   task automatic send(input int q, input int nb, input logic [7:0] op);
      int nclk;
      qpi_mode = q[0];
      waitc(H);
      cs_n = 1'b0;
      waitc(H);
      nclk = q ? nb / 4 : nb;
      for (int i = 0; i < nclk; i++) begin
         sclk = 1'b0;
         if (q) sio = (i == 0) ? op[7:4] : (i == 1) ? op[3:0] : 4'h0;
         else   sio = {3'b101, (i < 8) ? op[7 - i] : 1'b0};
         waitc(H);
         sclk = 1'b1;
         waitc(H);
      end
   endtask

   task automatic end_frame();
      sclk = 1'b0;
      waitc(H);
      cs_n = 1'b1;
      waitc(H);
   endtask

   task automatic read_sig(input int n, input string req, input bit expect_on);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         waitc(H);
         check(req, so_oe, expect_on);
         if (expect_on) check(req, so, SIG[7 - (i % 8)]);
         sclk = 1'b1;
         waitc(H);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      waitc(5);
      // R1 reset state
      check("R1 pd", pd_active, 0);
      check("R1 trans", transitioning, 0);
      check("R1 oe", so_oe, 0);
      rst_n = 1'b1;
      waitc(5);

      for (int v = 0; v < NV; v++) begin
         clr_count();
         send(int'(VEC[v][39:32]), int'(VEC[v][31:24]), VEC[v][23:16]);
         end_frame();
         waitc(SETTLE);
         check($sformatf("R4/R6 vec%0d pd", v), pd_active, int'(VEC[v][15:8]));
         check($sformatf("R5/R7 vec%0d wait", v), tcount,
               (VEC[v][7:0] == 8'd1) ? TDP : (VEC[v][7:0] == 8'd2) ? TRES : 0);
      end

      // R8 signature from standby, two repeats
      clr_count();
      send(0, 32, 8'hAB);
      read_sig(16, "R8 sig standby", 1'b1);
      end_frame();
      waitc(SETTLE);
      check("R8 oe off", so_oe, 0);
      check("R8 standby", pd_active, 0);
      check("R8 no wait", tcount, 0);

      // R8 signature while asleep wakes after one byte
      send(0, 8, 8'hB9); end_frame(); waitc(SETTLE);
      clr_count();
      send(0, 32, 8'hAB);
      read_sig(8, "R8 sig asleep", 1'b1);
      end_frame();
      waitc(SETTLE);
      check("R8 wake pd", pd_active, 0);
      check("R8 wake wait", tcount, TRES);

      // R9 busy blocks wake and signature
      send(0, 8, 8'hB9); end_frame(); waitc(SETTLE);
      busy = 1'b1;
      send(0, 8, 8'hAB); end_frame(); waitc(SETTLE);
      check("R9 pd busy", pd_active, 1);
      send(0, 32, 8'hAB);
      read_sig(2, "R9 sig busy", 1'b0);
      end_frame(); waitc(SETTLE);
      check("R9 pd busy sig", pd_active, 1);
      busy = 1'b0;

      // R10 reset opcode leaves sleep at once
      clr_count();
      send(0, 8, 8'h99); end_frame(); waitc(SETTLE);
      check("R10 pd", pd_active, 0);
      check("R10 wait", tcount, 0);

      // R11 frame started during entry wait is ignored
      send(0, 8, 8'hB9); end_frame();
      send(0, 8, 8'hAB);
      sclk = 1'b0;
      waitc(TDP + 40);
      check("R11 asleep mid frame", pd_active, 1);
      end_frame(); waitc(SETTLE);
      check("R11 still asleep", pd_active, 1);
      send(0, 8, 8'hAB); end_frame(); waitc(SETTLE);
      check("R11 later wake", pd_active, 0);

      // R1 hardware reset while asleep
      send(0, 8, 8'hB9); end_frame(); waitc(SETTLE);
      check("R1 asleep before reset", pd_active, 1);
      rst_n = 1'b0; waitc(3);
      check("R1 reset pd", pd_active, 0);
      check("R1 reset trans", transitioning, 0);
      rst_n = 1'b1; waitc(5);

      // R12
      check("R12 exclusive", both_cnt, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule